// File: doc/BRIEF.md
# Dual-Bank Protection Region Checker

This block decides whether a memory access may proceed. It holds a parameterised number of address windows. Each window is described by a base word and a limit word. Every window is stored twice: one copy serves the secure world and one serves the non-secure world. The security attribute of each request picks the copy. This holds both for configuration reads and writes and for address lookups.

A lookup presents an address, a security attribute, a privilege flag and an access type (read, write or instruction fetch). One cycle later the block returns:

- whether a window matched, and which one;
- the read, write and execute rights that apply;
- whether the access faults;
- whether the fixed privileged default map was used.

Every configuration write pulses an invalidate output, so that cached translations downstream can be dropped.

Top module: `prot_region_unit`

## Requirements
- R1: After reset every base and limit word in both banks reads as zero, and `res_valid` and `flush_o` are low.
- R2: The two banks are independent. A configuration access with `cfg_sec`=1 reads or writes only the secure copy, and one with `cfg_sec`=0 reads or writes only the non-secure copy. `cfg_sel`=0 selects the base word and `cfg_sel`=1 selects the limit word. Reads are combinational.
- R3: A configuration index at or above NUM_REGIONS reads as zero. A write to such an index changes no stored word.
- R4: A window covers the addresses from {base[31:5], 5'b00000} to {limit[31:5], 5'b11111}, both ends included. Bits [4:0] of the stored words never move the window edges.
- R5: Bit 0 of the limit word enables the window. A window whose enable bit is 0 never matches.
- R6: Bits [2:1] of the base word give the rights:
  - 00: read/write for privileged accesses only;
  - 01: read/write at any privilege;
  - 10: read-only, privileged only;
  - 11: read-only at any privilege.
- R7: Bit 0 of the base word forbids execution. Any address at or above SYS_BASE (default 0xE000_0000) is never executable, whatever that bit says.
- R8: When two or more enabled windows of the selected bank match, the lookup faults. It then reports no hit and no rights.
- R9: A privileged lookup that matches no window uses the default map. In that case `res_bg`=1, read and write are allowed, and execute is allowed only below SYS_BASE.
- R10: An unprivileged lookup that matches no window faults, with no rights.
- R11: A lookup uses only the bank selected by `lk_sec`.
- R12: `flush_o` is high for exactly the cycle after each cycle with `cfg_we` high.
- R13: A lookup accepted with `lk_valid` on a clock edge produces `res_valid` and its results after that edge. `res_fault` is set when the rights do not allow the access type: `lk_type` 0 is read, 1 is write, 2 is fetch, and 3 is treated as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base word, 1 selects the limit word |
| cfg_sec | input | 1 | Bank for the configuration access (1 = secure) |
| cfg_idx | input | CFG_IDX_W | Window index for the configuration access |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_sec | input | 1 | Bank for the lookup (1 = secure) |
| lk_priv | input | 1 | Lookup is privileged |
| lk_type | input | 2 | 0 read, 1 write, 2 fetch |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Exactly one window matched |
| res_region | output | RIDX_W | Index of the matching window |
| res_rd_ok | output | 1 | Read allowed |
| res_wr_ok | output | 1 | Write allowed |
| res_exec_ok | output | 1 | Execute allowed |
| res_fault | output | 1 | Access refused |
| res_bg | output | 1 | Default map used |
| flush_o | output | 1 | Invalidate pulse after a configuration write |

## Verification
Lookups are aimed at the first and last byte of a window and at the bytes just outside it, which separates a correct 32-byte rounding from an off-by-one edge. The same address is looked up in both banks and at both privilege levels, which tells bank selection apart from the default-map and unprivileged-miss paths. Windows using each of the four rights codes are probed with read, write and fetch, and one window sits in the system range with execute-never clear. An overlapping window is added and then disabled, which separates the overlap fault from the enable bit. Out-of-range indices are written and read back, next to an aliasing in-range index.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   localparam int GRAN_BITS  = 5;
   localparam int LIM_EN_BIT = 0;
   localparam int XN_BIT     = 0;
   localparam int AP_LSB     = 1;
   localparam int AP_MSB     = 2;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } rights_t;

   function automatic rights_t decode_rights(input logic [1:0] ap, input logic priv,
                                             input logic xn, input logic sys);
      rights_t r;
      r.rd = priv | ap[0];
      r.wr = r.rd & ~ap[1];
      r.ex = r.rd & ~xn & ~sys;
      return r;
   endfunction

   function automatic logic refuse(input rights_t r, input acc_kind_e k);
      logic f;
      case (k)
         ACC_WRITE: f = ~r.wr;
         ACC_FETCH: f = ~r.ex;
         default:   f = ~r.rd;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/prot_region_store.sv
module prot_region_store #(
   parameter int NUM_REGIONS = 8,
   parameter int CFG_IDX_W   = 4,
   parameter int DATA_W      = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic                              cfg_sel,
   input  logic                              cfg_sec,
   input  logic [CFG_IDX_W-1:0]              cfg_idx,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [DATA_W-1:0]                 cfg_rdata,
   input  logic                              lk_sec,
   output logic [NUM_REGIONS-1:0][DATA_W-1:0] base_o,
   output logic [NUM_REGIONS-1:0][DATA_W-1:0] lim_o
);
   localparam int NBANK = 2;
   localparam logic [CFG_IDX_W:0] NREG = (CFG_IDX_W+1)'(NUM_REGIONS);

   logic [NBANK-1:0][NUM_REGIONS-1:0][DATA_W-1:0] base_q, lim_q;
   logic in_range;

   assign in_range = ({1'b0, cfg_idx} < NREG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         lim_q  <= '0;
      end else if (cfg_we && in_range) begin
         for (int b = 0; b < NBANK; b++) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
               if (cfg_sec == 1'(b) && cfg_idx == CFG_IDX_W'(r)) begin
                  if (cfg_sel) lim_q[b][r]  <= cfg_wdata;
                  else         base_q[b][r] <= cfg_wdata;
               end
            end
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (in_range) begin
         for (int r = 0; r < NUM_REGIONS; r++) begin
            if (cfg_idx == CFG_IDX_W'(r))
               cfg_rdata = cfg_sel ? lim_q[cfg_sec][r] : base_q[cfg_sec][r];
         end
      end
   end

   assign base_o = base_q[lk_sec];
   assign lim_o  = lim_q[lk_sec];

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
   import prot_region_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int DATA_W      = 32
) (
   input  logic [DATA_W-1:0]                  addr_i,
   input  logic [NUM_REGIONS-1:0][DATA_W-1:0] base_i,
   input  logic [NUM_REGIONS-1:0][DATA_W-1:0] lim_i,
   output logic [NUM_REGIONS-1:0]             hit_o
);
   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
      logic [DATA_W-1:0] lo, hi;
      assign lo = {base_i[r][DATA_W-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
      assign hi = {lim_i[r][DATA_W-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
      assign hit_o[r] = lim_i[r][LIM_EN_BIT] && (addr_i >= lo) && (addr_i <= hi);
   end

endmodule

// File: rtl/prot_region_resolve.sv
module prot_region_resolve
   import prot_region_pkg::*;
#(
   parameter int          NUM_REGIONS = 8,
   parameter int          RIDX_W      = 3,
   parameter int          DATA_W      = 32,
   parameter logic [31:0] SYS_BASE    = 32'hE000_0000
) (
   input  logic [NUM_REGIONS-1:0]             hit_i,
   input  logic [NUM_REGIONS-1:0][DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0]                  addr_i,
   input  logic                               priv_i,
   input  logic [1:0]                         kind_i,
   output logic                               hit_o,
   output logic [RIDX_W-1:0]                  region_o,
   output rights_t                            rights_o,
   output logic                               fault_o,
   output logic                               bg_o
);
   logic [RIDX_W-1:0] sel;
   logic [DATA_W-1:0] sel_base;
   logic              sys;
   logic              multi, none;

   assign sys   = (addr_i >= DATA_W'(SYS_BASE));
   assign multi = ($countones(hit_i) > 1);
   assign none  = (hit_i == '0);

   always_comb begin
      sel = '0;
      for (int r = 0; r < NUM_REGIONS; r++)
         if (hit_i[r]) sel = RIDX_W'(r);
   end

   assign sel_base = base_i[sel];

   always_comb begin
      hit_o    = 1'b0;
      region_o = '0;
      bg_o     = 1'b0;
      rights_o = '0;
      if (multi) begin
         fault_o = 1'b1;
      end else if (!none) begin
         hit_o    = 1'b1;
         region_o = sel;
         rights_o = decode_rights(sel_base[AP_MSB:AP_LSB], priv_i, sel_base[XN_BIT], sys);
         fault_o  = refuse(rights_o, acc_kind_e'(kind_i));
      end else if (priv_i) begin
         bg_o     = 1'b1;
         rights_o = '{rd: 1'b1, wr: 1'b1, ex: ~sys};
         fault_o  = refuse(rights_o, acc_kind_e'(kind_i));
      end else begin
         fault_o = 1'b1;
      end
   end

endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
   import prot_region_pkg::*;
#(
   parameter int          NUM_REGIONS = 8,
   parameter int          CFG_IDX_W   = 4,
   parameter logic [31:0] SYS_BASE    = 32'hE000_0000,
   localparam int         RIDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic                 cfg_sel,
   input  logic                 cfg_sec,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   input  logic                 lk_valid,
   input  logic [31:0]          lk_addr,
   input  logic                 lk_sec,
   input  logic                 lk_priv,
   input  logic [1:0]           lk_type,
   output logic                 res_valid,
   output logic                 res_hit,
   output logic [RIDX_W-1:0]    res_region,
   output logic                 res_rd_ok,
   output logic                 res_wr_ok,
   output logic                 res_exec_ok,
   output logic                 res_fault,
   output logic                 res_bg,
   output logic                 flush_o
);
   localparam int DATA_W = 32;

   if (NUM_REGIONS < 1 || NUM_REGIONS > 64) begin : g_bad_count
      $error("NUM_REGIONS must lie in 1..64");
   end
   if (CFG_IDX_W < RIDX_W) begin : g_bad_idx
      $error("CFG_IDX_W too narrow for NUM_REGIONS");
   end

   logic [NUM_REGIONS-1:0][DATA_W-1:0] bank_base, bank_lim;
   logic [NUM_REGIONS-1:0]             hit_vec;
   logic                               c_hit, c_fault, c_bg;
   logic [RIDX_W-1:0]                  c_region;
   rights_t                            c_rights;

   prot_region_store #(
      .NUM_REGIONS(NUM_REGIONS), .CFG_IDX_W(CFG_IDX_W), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_sec(cfg_sec), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .lk_sec(lk_sec), .base_o(bank_base), .lim_o(bank_lim)
   );

   prot_region_match #(
      .NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W)
   ) u_match (
      .addr_i(lk_addr), .base_i(bank_base), .lim_i(bank_lim), .hit_o(hit_vec)
   );

   prot_region_resolve #(
      .NUM_REGIONS(NUM_REGIONS), .RIDX_W(RIDX_W), .DATA_W(DATA_W), .SYS_BASE(SYS_BASE)
   ) u_resolve (
      .hit_i(hit_vec), .base_i(bank_base), .addr_i(lk_addr), .priv_i(lk_priv),
      .kind_i(lk_type), .hit_o(c_hit), .region_o(c_region), .rights_o(c_rights),
      .fault_o(c_fault), .bg_o(c_bg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         flush_o     <= 1'b0;
         res_hit     <= 1'b0;
         res_region  <= '0;
         res_rd_ok   <= 1'b0;
         res_wr_ok   <= 1'b0;
         res_exec_ok <= 1'b0;
         res_fault   <= 1'b0;
         res_bg      <= 1'b0;
      end else begin
         res_valid <= lk_valid;
         flush_o   <= cfg_we;
         if (lk_valid) begin
            res_hit     <= c_hit;
            res_region  <= c_region;
            res_rd_ok   <= c_rights.rd;
            res_wr_ok   <= c_rights.wr;
            res_exec_ok <= c_rights.ex;
            res_fault   <= c_fault;
            res_bg      <= c_bg;
         end
      end
   end

endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker #(
   parameter int          NUM_REGIONS = 8,
   parameter int          CFG_IDX_W   = 4,
   parameter logic [31:0] SYS_BASE    = 32'hE000_0000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [CFG_IDX_W-1:0] cfg_idx,
   input logic [31:0]          cfg_rdata,
   input logic                 lk_valid,
   input logic [31:0]          lk_addr,
   input logic                 lk_priv,
   input logic                 res_valid,
   input logic                 res_hit,
   input logic                 res_rd_ok,
   input logic                 res_wr_ok,
   input logic                 res_exec_ok,
   input logic                 res_bg,
   input logic                 flush_o
);
   localparam logic [CFG_IDX_W:0] NREG = (CFG_IDX_W+1)'(NUM_REGIONS);

   assert_flush_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> flush_o);
   assert_flush_only_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> !flush_o);
   assert_result_follows_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   assert_oob_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cfg_idx} >= NREG) |-> (cfg_rdata == 32'h0));
   assert_sys_never_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_exec_ok) |-> ($past(lk_addr) < SYS_BASE));
   assert_no_bg_unpriv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(lk_priv)) |-> !res_bg);
   assert_hit_bg_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot0({res_hit, res_bg}));
   assert_write_implies_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_wr_ok) |-> res_rd_ok);

endmodule

bind prot_region_unit prot_region_checker #(
   .NUM_REGIONS(NUM_REGIONS), .CFG_IDX_W(CFG_IDX_W), .SYS_BASE(SYS_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rdata(cfg_rdata),
   .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_priv(lk_priv), .res_valid(res_valid),
   .res_hit(res_hit), .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok),
   .res_exec_ok(res_exec_ok), .res_bg(res_bg), .flush_o(flush_o)
);

// File: tb/prot_region_unit_bench.sv
module prot_region_unit_bench;
   localparam int NR = 8;
   localparam logic [31:0] SYSB = 32'hE000_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, cfg_sel = 0, cfg_sec = 0;
   logic [3:0] cfg_idx = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic lk_valid = 0, lk_sec = 0, lk_priv = 0;
   logic [31:0] lk_addr = '0;
   logic [1:0] lk_type = '0;
   logic res_valid, res_hit, res_rd_ok, res_wr_ok, res_exec_ok, res_fault, res_bg, flush_o;
   logic [2:0] res_region;

   int checks = 0, errors = 0;
   logic [31:0] mb [2][NR];
   logic [31:0] ml [2][NR];
   logic [8:0] exp_q [$];
   string tag_q [$];

   always #10 clk = ~clk;

   prot_region_unit u_prot_region_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_sec(cfg_sec),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_sec(lk_sec), .lk_priv(lk_priv),
      .lk_type(lk_type), .res_valid(res_valid), .res_hit(res_hit),
      .res_region(res_region), .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok),
      .res_exec_ok(res_exec_ok), .res_fault(res_fault), .res_bg(res_bg), .flush_o(flush_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] model(input logic [31:0] a, input logic s,
                                        input logic p, input logic [1:0] t);
      int cnt = 0;
      int idx = 0;
      logic rd = 0, wr = 0, ex = 0, flt = 0, bg = 0, hit = 0;
      logic sys = (a >= SYSB);
      for (int r = 0; r < NR; r++) begin
         if (ml[s][r][0] && a >= {mb[s][r][31:5], 5'b0} && a <= {ml[s][r][31:5], 5'h1f}) begin
            cnt++;
            idx = r;
         end
      end
      if (cnt > 1) begin
         flt = 1;
         idx = 0;
      end else begin
         if (cnt == 1) begin
            hit = 1;
            rd  = p | mb[s][idx][1];
            wr  = rd & ~mb[s][idx][2];
            ex  = rd & ~mb[s][idx][0] & ~sys;
         end else if (p) begin
            bg = 1; rd = 1; wr = 1; ex = ~sys;
         end
         if (cnt == 0 && !p) flt = 1;
         else flt = (t == 2'd1) ? ~wr : (t == 2'd2) ? ~ex : ~rd;
      end
      return {hit, 3'(idx), rd, wr, ex, flt, bg};
   endfunction

   task automatic reg_wr(input logic s, input logic sel, input logic [3:0] idx,
                         input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sec = s; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
      if (idx < NR) begin
         if (sel) ml[s][idx] = d;
         else     mb[s][idx] = d;
      end
      @(negedge clk);
      chk("R12 flush after write", {31'b0, flush_o}, 32'd1);
      cfg_we = 0;
   endtask

   task automatic reg_rd(input string req, input logic s, input logic sel,
                         input logic [3:0] idx, input logic [31:0] exp);
      @(negedge clk);
      cfg_sec = s; cfg_sel = sel; cfg_idx = idx;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic look(input string req, input logic [31:0] a, input logic s,
                       input logic p, input logic [1:0] t);
      @(negedge clk);
      lk_valid = 1; lk_addr = a; lk_sec = s; lk_priv = p; lk_type = t;
      exp_q.push_back(model(a, s, p, t));
      tag_q.push_back(req);
      @(negedge clk);
      lk_valid = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R13 unexpected result actual=1 expected=0");
         end else begin
            chk(tag_q.pop_front(),
                {23'b0, res_hit, res_region, res_rd_ok, res_wr_ok, res_exec_ok, res_fault, res_bg},
                {23'b0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      #4_000_000;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < NR; r++) begin mb[b][r] = '0; ml[b][r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 res_valid low", {31'b0, res_valid}, 32'd0);
      chk("R1 flush low", {31'b0, flush_o}, 32'd0);
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < NR; r++) begin
            reg_rd("R1 base zero", b[0], 1'b0, 4'(r), 32'h0);
            reg_rd("R1 limit zero", b[0], 1'b1, 4'(r), 32'h0);
         end
      look("R1 R10 empty unpriv miss", 32'h0000_0000, 0, 0, 2'd0);

      reg_wr(0, 0, 4'd0, 32'h0000_1002);
      reg_wr(0, 1, 4'd0, 32'h0000_1FE1);
      @(negedge clk);
      chk("R12 flush drops", {31'b0, flush_o}, 32'd0);
      reg_wr(1, 0, 4'd0, 32'h0000_8000);
      reg_wr(1, 1, 4'd0, 32'h0000_80E1);
      reg_wr(0, 0, 4'd1, 32'h0000_3007);
      reg_wr(0, 1, 4'd1, 32'h0000_30E1);
      reg_wr(0, 0, 4'd3, 32'hE000_0002);
      reg_wr(0, 1, 4'd3, 32'hE000_0FE1);
      reg_wr(0, 0, 4'd4, 32'h0000_5004);
      reg_wr(0, 1, 4'd4, 32'h0000_50E1);

      reg_rd("R2 ns base", 0, 0, 4'd0, 32'h0000_1002);
      reg_rd("R2 ns limit", 0, 1, 4'd0, 32'h0000_1FE1);
      reg_rd("R2 s base", 1, 0, 4'd0, 32'h0000_8000);
      reg_rd("R2 s limit", 1, 1, 4'd0, 32'h0000_80E1);
      reg_rd("R2 s r1 untouched", 1, 0, 4'd1, 32'h0);

      reg_wr(0, 0, 4'd9, 32'hFFFF_FFFF);
      reg_wr(1, 1, 4'd15, 32'hFFFF_FFFF);
      reg_rd("R3 oob read", 0, 0, 4'd9, 32'h0);
      reg_rd("R3 oob read s", 1, 1, 4'd15, 32'h0);
      reg_rd("R3 alias r1 intact", 0, 0, 4'd1, 32'h0000_3007);
      reg_rd("R3 alias s r7 intact", 1, 1, 4'd7, 32'h0);

      look("R4 R6 base edge unpriv read", 32'h0000_1000, 0, 0, 2'd0);
      look("R4 limit edge unpriv write", 32'h0000_1FFF, 0, 0, 2'd1);
      look("R4 below base", 32'h0000_0FFF, 0, 1, 2'd0);
      look("R4 R10 above limit unpriv", 32'h0000_2000, 0, 0, 2'd0);
      look("R9 bg priv write", 32'h0000_2000, 0, 1, 2'd1);
      look("R9 bg priv fetch", 32'h0000_2000, 0, 1, 2'd2);
      look("R4 fetch in window", 32'h0000_1010, 0, 0, 2'd2);
      look("R11 secure bank miss", 32'h0000_1000, 1, 1, 2'd0);
      look("R11 R6 s ap00 unpriv", 32'h0000_8010, 1, 0, 2'd0);
      look("R6 s ap00 priv write", 32'h0000_80FF, 1, 1, 2'd1);
      look("R11 ns miss on s window", 32'h0000_8010, 0, 0, 2'd0);
      look("R6 ap11 unpriv read", 32'h0000_3020, 0, 0, 2'd0);
      look("R6 ap11 write fault", 32'h0000_3020, 0, 1, 2'd1);
      look("R7 xn fetch fault", 32'h0000_3020, 0, 1, 2'd2);
      look("R6 ap10 priv write", 32'h0000_5000, 0, 1, 2'd1);
      look("R6 ap10 unpriv read", 32'h0000_5000, 0, 0, 2'd0);
      look("R6 ap10 priv read", 32'h0000_50FF, 0, 1, 2'd3);
      look("R7 sys window fetch", 32'hE000_0100, 0, 0, 2'd2);
      look("R7 sys window read", 32'hE000_0100, 0, 0, 2'd0);
      look("R7 R9 bg sys fetch", 32'hF000_0000, 0, 1, 2'd2);

      reg_wr(0, 0, 4'd2, 32'h0000_1802);
      reg_wr(0, 1, 4'd2, 32'h0000_18E1);
      look("R8 overlap fault", 32'h0000_1810, 0, 1, 2'd0);
      look("R8 outside overlap", 32'h0000_1900, 0, 1, 2'd0);
      reg_wr(0, 1, 4'd2, 32'h0000_18E0);
      look("R5 disabled window", 32'h0000_1810, 0, 1, 2'd0);
      reg_wr(0, 1, 4'd4, 32'h0000_50E0);
      look("R5 disabled unpriv", 32'h0000_5000, 0, 0, 2'd0);

      repeat (3) @(negedge clk);
      chk("R13 all results seen", exp_q.size(), 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule